// File: doc/BRIEF.md
# Register-write display list engine

This block is a bus master that walks a list of configuration writes held in memory and replays them as register writes on an internal configuration bus. Software hands it the address of a list. The engine reads the list one 32-bit word at a time over a simple request/response read port. Every (address, data) pair it reads becomes one write strobe with address and data. When a list finishes, the engine can raise a frame-end interrupt and can start the next list by itself.

There are two modes, chosen by the `hdr_mode` input when a list is taken. In header mode the launch address points at a header. The header gives the number of bodies, a byte count and an address for each body, a next-header pointer and two flag bits. A chain of headers can run back to back. A header that points at itself repeats on every frame until software supplies a replacement. In headerless mode the launch gives a single body address and byte size, and that body runs once. In both modes a launch write sets an update bit. The engine clears that bit when it takes the launch.

Top module: `reglist_engine`

## Requirements
- R1: A body entry is 8 bytes: the first 32-bit word is the register address, of which the low RAW bits drive `cfg_addr`, and the second word drives `cfg_data`. Each entry produces exactly one single-cycle `cfg_wr`, and entries are written in ascending memory order.
- R2: Header word offsets in bytes from the header base: body count at 0, byte count of body i at 4+8i, address of body i at 8+8i, next-header address at 4+8·NB, flags at 8+8·NB.
- R3: The body-count field gives the number of bodies beyond the first, so 0 means one body. Bodies run in index order 0..count. A count above NB-1 is treated as NB-1.
- R4: A body holds byte_count/8 entries. A byte count of 0 is skipped without any `cfg_wr`.
- R5: Flags bit 1 set makes `frame_irq` pulse for one cycle when that list completes. A chain in which only the last list sets bit 1 gives exactly one pulse.
- R6: Flags bit 0 set makes the engine fetch and run the header at the next-header address without a new launch. A self-pointing header repeats.
- R7: A list with bit 0 set and bit 1 clear is a chain middle, and its next header always runs next. On any other completion, a waiting launch is taken before auto-start.
- R8: `launch_upd` is high in the cycle after `launch_wr` and stays high until the engine takes the launch. An idle engine takes it one cycle later. A second launch before the take replaces the first.
- R9: In headerless mode (`hdr_mode`=0), `launch_addr` is the body address and `launch_size` its byte count. The body runs once, `frame_irq` pulses at the end and nothing auto-starts. Size 0 gives no writes but still one pulse.
- R10: `busy` is high from the take until the list sequence ends and low when idle. While `busy` is low there is no `cfg_wr` and no read request.
- R11: A read request stays valid with a stable address until `mem_req_ready`, and at most one read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hdr_mode | input | 1 | 1 = header mode, 0 = headerless mode |
| launch_wr | input | 1 | Software launch write strobe |
| launch_addr | input | AW | Header address, or body address in headerless mode |
| launch_size | input | SW | Body byte count (headerless mode only) |
| launch_upd | output | 1 | Update bit: launch written but not yet taken |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | AW | Read byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |
| cfg_wr | output | 1 | Register write strobe |
| cfg_addr | output | RAW | Register address |
| cfg_data | output | 32 | Register data |
| frame_irq | output | 1 | Frame-end interrupt pulse |
| busy | output | 1 | List processing in progress |

## Verification
The bench builds the engine with NB=4, so the header is only 44 bytes and the next and flags words sit at offsets 36 and 40. With NB=4, a body-count field of 6 exercises the clamp to the last body slot. The memory model stalls `mem_req_ready` at random and returns data after one to three cycles, which exercises the request hold and the single outstanding read. Directed lists cover zero-length bodies, a two-list chain, a self-looping list replaced by a launch, and a launch made during a chain middle.

// File: rtl/rle_pkg.sv
package rle_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HCNT,
        ST_HLEN,
        ST_HPTR,
        ST_BCHK,
        ST_EADR,
        ST_EDAT,
        ST_HNXT,
        ST_HFLG
    } rle_state_e;

    localparam int unsigned FLG_AUTO = 0;
    localparam int unsigned FLG_IRQ  = 1;
endpackage

// File: rtl/rle_launch.sv
module rle_launch #(
    parameter int unsigned AW = 32,
    parameter int unsigned SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [SW-1:0] size_i,
    input  logic          take_i,
    output logic          valid_o,
    output logic [AW-1:0] addr_o,
    output logic [SW-1:0] size_o
);
    typedef struct packed {
        logic          v;
        logic [AW-1:0] a;
        logic [SW-1:0] s;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (take_i) slot_d.v = 1'b0;
        if (wr_i) begin
            slot_d.v = 1'b1;
            slot_d.a = addr_i;
            slot_d.s = size_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign valid_o = slot_q.v;
    assign addr_o  = slot_q.a;
    assign size_o  = slot_q.s;
endmodule

// File: rtl/rle_rdport.sv
module rle_rdport #(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_i,
    input  logic [AW-1:0] addr_i,
    input  logic          req_ready_i,
    output logic          req_valid_o,
    output logic [AW-1:0] req_addr_o
);
    typedef struct packed {
        logic          v;
        logic [AW-1:0] a;
    } req_t;

    req_t req_d, req_q;

    always_comb begin
        req_d = req_q;
        if (req_q.v && req_ready_i) req_d.v = 1'b0;
        if (issue_i) begin
            req_d.v = 1'b1;
            req_d.a = addr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    assign req_valid_o = req_q.v;
    assign req_addr_o  = req_q.a;
endmodule

// File: rtl/rle_seq.sv
module rle_seq
    import rle_pkg::*;
#(
    parameter int unsigned AW  = 32,
    parameter int unsigned SW  = 16,
    parameter int unsigned RAW = 16,
    parameter int unsigned NB  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hdr_mode_i,
    input  logic           pend_valid_i,
    input  logic [AW-1:0]  pend_addr_i,
    input  logic [SW-1:0]  pend_size_i,
    output logic           take_o,
    output logic           issue_o,
    output logic [AW-1:0]  issue_addr_o,
    input  logic           rd_valid_i,
    input  logic [31:0]    rd_data_i,
    output logic           reg_wr_o,
    output logic [RAW-1:0] reg_addr_o,
    output logic [31:0]    reg_data_o,
    output logic           irq_o,
    output logic           busy_o
);
    localparam int unsigned IW      = (NB > 1) ? $clog2(NB) : 1;
    localparam int unsigned LW      = 29;
    localparam int unsigned OFF_NXT = 4 + 8 * NB;
    localparam int unsigned OFF_FLG = 8 + 8 * NB;

    typedef struct packed {
        rle_state_e     st;
        logic           ph;
        logic           hl;
        logic [AW-1:0]  hdr;
        logic [IW-1:0]  idx;
        logic [IW-1:0]  cnt;
        logic [LW-1:0]  left;
        logic [AW-1:0]  ptr;
        logic [RAW-1:0] radr;
        logic [AW-1:0]  nxt;
        logic           wr;
        logic [RAW-1:0] wa;
        logic [31:0]    wd;
        logic           irq;
    } seq_t;

    seq_t n, q;

    logic          fin, go, go_hdr;
    logic [1:0]    fflags;
    logic [AW-1:0] go_addr;
    logic [SW-1:0] go_size;
    logic [AW-1:0] idx_off;

    assign idx_off = AW'({q.idx, 3'b000});

    // Byte address of the word fetched in the current state
    always_comb begin
        case (q.st)
            ST_HCNT: issue_addr_o = q.hdr;
            ST_HLEN: issue_addr_o = q.hdr + AW'(4) + idx_off;
            ST_HPTR: issue_addr_o = q.hdr + AW'(8) + idx_off;
            ST_EADR: issue_addr_o = q.ptr;
            ST_EDAT: issue_addr_o = q.ptr + AW'(4);
            ST_HNXT: issue_addr_o = q.hdr + AW'(OFF_NXT);
            ST_HFLG: issue_addr_o = q.hdr + AW'(OFF_FLG);
            default: issue_addr_o = q.hdr;
        endcase
    end

    always_comb begin
        n       = q;
        n.wr    = 1'b0;
        n.irq   = 1'b0;
        take_o  = 1'b0;
        issue_o = 1'b0;
        fin     = 1'b0;
        fflags  = 2'b00;
        go      = 1'b0;
        go_hdr  = 1'b0;
        go_addr = '0;
        go_size = '0;

        case (q.st)
            ST_IDLE: begin
                if (pend_valid_i) begin
                    take_o  = 1'b1;
                    go      = 1'b1;
                    go_hdr  = hdr_mode_i;
                    go_addr = pend_addr_i;
                    go_size = pend_size_i;
                end
            end
            ST_BCHK: begin
                if (q.left != '0) begin
                    n.st = ST_EADR;
                end else if (q.hl) begin
                    fin    = 1'b1;
                    fflags = 2'b10;
                end else if (q.idx == q.cnt) begin
                    n.st = ST_HNXT;
                end else begin
                    n.idx = q.idx + IW'(1);
                    n.st  = ST_HLEN;
                end
            end
            default: begin
                if (!q.ph) begin
                    issue_o = 1'b1;
                    n.ph    = 1'b1;
                end else if (rd_valid_i) begin
                    n.ph = 1'b0;
                    case (q.st)
                        ST_HCNT: begin
                            n.cnt = (rd_data_i > 32'(NB - 1)) ? IW'(NB - 1)
                                                              : rd_data_i[IW-1:0];
                            n.st  = ST_HLEN;
                        end
                        ST_HLEN: begin
                            n.left = rd_data_i[31:3];
                            n.st   = ST_HPTR;
                        end
                        ST_HPTR: begin
                            n.ptr = rd_data_i[AW-1:0];
                            n.st  = ST_BCHK;
                        end
                        ST_EADR: begin
                            n.radr = rd_data_i[RAW-1:0];
                            n.st   = ST_EDAT;
                        end
                        ST_EDAT: begin
                            n.wr   = 1'b1;
                            n.wa   = q.radr;
                            n.wd   = rd_data_i;
                            n.ptr  = q.ptr + AW'(8);
                            n.left = q.left - LW'(1);
                            n.st   = ST_BCHK;
                        end
                        ST_HNXT: begin
                            n.nxt = rd_data_i[AW-1:0];
                            n.st  = ST_HFLG;
                        end
                        default: begin
                            fin    = 1'b1;
                            fflags = rd_data_i[1:0];
                        end
                    endcase
                end
            end
        endcase

        // List completion: interrupt and choice of what runs next
        if (fin) begin
            n.irq = fflags[FLG_IRQ];
            if (fflags[FLG_AUTO] && !fflags[FLG_IRQ]) begin
                go      = 1'b1;
                go_hdr  = 1'b1;
                go_addr = q.nxt;
            end else if (pend_valid_i) begin
                take_o  = 1'b1;
                go      = 1'b1;
                go_hdr  = hdr_mode_i;
                go_addr = pend_addr_i;
                go_size = pend_size_i;
            end else if (fflags[FLG_AUTO]) begin
                go      = 1'b1;
                go_hdr  = 1'b1;
                go_addr = q.nxt;
            end else begin
                n.st = ST_IDLE;
            end
        end

        if (go) begin
            n.ph  = 1'b0;
            n.idx = '0;
            if (go_hdr) begin
                n.hl  = 1'b0;
                n.hdr = go_addr;
                n.st  = ST_HCNT;
            end else begin
                n.hl   = 1'b1;
                n.ptr  = go_addr;
                n.left = LW'(go_size >> 3);
                n.st   = ST_BCHK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= n;
        end
    end

    assign reg_wr_o   = q.wr;
    assign reg_addr_o = q.wa;
    assign reg_data_o = q.wd;
    assign irq_o      = q.irq;
    assign busy_o     = (q.st != ST_IDLE);
endmodule

// File: rtl/reglist_engine.sv
module reglist_engine #(
    parameter int unsigned AW  = 32,
    parameter int unsigned SW  = 16,
    parameter int unsigned RAW = 16,
    parameter int unsigned NB  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hdr_mode,
    input  logic           launch_wr,
    input  logic [AW-1:0]  launch_addr,
    input  logic [SW-1:0]  launch_size,
    output logic           launch_upd,
    output logic           mem_req_valid,
    input  logic           mem_req_ready,
    output logic [AW-1:0]  mem_req_addr,
    input  logic           mem_rsp_valid,
    input  logic [31:0]    mem_rsp_data,
    output logic           cfg_wr,
    output logic [RAW-1:0] cfg_addr,
    output logic [31:0]    cfg_data,
    output logic           frame_irq,
    output logic           busy
);
    logic          take;
    logic [AW-1:0] pend_addr;
    logic [SW-1:0] pend_size;
    logic          issue;
    logic [AW-1:0] issue_addr;

    rle_launch #(.AW(AW), .SW(SW)) i_launch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (launch_wr),
        .addr_i  (launch_addr),
        .size_i  (launch_size),
        .take_i  (take),
        .valid_o (launch_upd),
        .addr_o  (pend_addr),
        .size_o  (pend_size)
    );

    rle_rdport #(.AW(AW)) i_rdport (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_i     (issue),
        .addr_i      (issue_addr),
        .req_ready_i (mem_req_ready),
        .req_valid_o (mem_req_valid),
        .req_addr_o  (mem_req_addr)
    );

    rle_seq #(.AW(AW), .SW(SW), .RAW(RAW), .NB(NB)) i_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .hdr_mode_i   (hdr_mode),
        .pend_valid_i (launch_upd),
        .pend_addr_i  (pend_addr),
        .pend_size_i  (pend_size),
        .take_o       (take),
        .issue_o      (issue),
        .issue_addr_o (issue_addr),
        .rd_valid_i   (mem_rsp_valid),
        .rd_data_i    (mem_rsp_data),
        .reg_wr_o     (cfg_wr),
        .reg_addr_o   (cfg_addr),
        .reg_data_o   (cfg_data),
        .irq_o        (frame_irq),
        .busy_o       (busy)
    );
endmodule

// File: rtl/rle_checks.sv
module rle_checks #(
    parameter int unsigned AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          launch_wr,
    input logic          launch_upd,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic [AW-1:0] mem_req_addr,
    input logic          cfg_wr,
    input logic          frame_irq,
    input logic          busy
);
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_valid && !cfg_wr);

    a_r8_upd_set: assert property (@(posedge clk) disable iff (!rst_n)
        launch_wr |=> launch_upd);

    a_r8_idle_take: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && launch_upd |=> busy);

    a_r5_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_irq |=> !frame_irq);
endmodule

bind reglist_engine rle_checks #(.AW(AW)) i_rle_checks (
    .clk           (clk),
    .rst_n         (rst_n),
    .launch_wr     (launch_wr),
    .launch_upd    (launch_upd),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .cfg_wr        (cfg_wr),
    .frame_irq     (frame_irq),
    .busy          (busy)
);

// File: tb/test_reglist_engine.sv
module test_reglist_engine;
    localparam int unsigned AW  = 32;
    localparam int unsigned SW  = 16;
    localparam int unsigned RAW = 16;
    localparam int unsigned NB  = 4;
    localparam int unsigned OFF_NXT = 4 + 8 * NB;
    localparam int unsigned OFF_FLG = 8 + 8 * NB;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           hdr_mode = 1'b1;
    logic           launch_wr = 1'b0;
    logic [AW-1:0]  launch_addr = '0;
    logic [SW-1:0]  launch_size = '0;
    logic           launch_upd;
    logic           mem_req_valid;
    logic           mem_req_ready;
    logic [AW-1:0]  mem_req_addr;
    logic           mem_rsp_valid;
    logic [31:0]    mem_rsp_data;
    logic           cfg_wr;
    logic [RAW-1:0] cfg_addr;
    logic [31:0]    cfg_data;
    logic           frame_irq;
    logic           busy;

    always #2.5 clk = ~clk;

    reglist_engine #(.AW(AW), .SW(SW), .RAW(RAW), .NB(NB)) i_reglist_engine (
        .clk(clk), .rst_n(rst_n), .hdr_mode(hdr_mode),
        .launch_wr(launch_wr), .launch_addr(launch_addr), .launch_size(launch_size),
        .launch_upd(launch_upd),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .frame_irq(frame_irq), .busy(busy)
    );

    int n_chk = 0;
    int n_fail = 0;
    int irq_cnt = 0;
    bit rec = 1'b0;
    logic [31:0] mem [0:2047];
    logic [47:0] exp_q[$];
    logic [47:0] obs_q[$];

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Memory model: random ready, response 1..3 cycles after accept
    logic [AW-1:0] m_addr;
    int            m_dly;
    bit            m_has;
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_req_ready <= 1'b0;
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= '0;
            m_has         <= 1'b0;
            m_dly         <= 0;
        end else begin
            mem_rsp_valid <= 1'b0;
            if (mem_req_valid && mem_req_ready) begin
                m_addr <= mem_req_addr;
                m_dly  <= 1 + int'($urandom % 3);
                m_has  <= 1'b1;
            end else if (m_has) begin
                if (m_dly == 1) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_data  <= mem[m_addr[12:2]];
                    m_has         <= 1'b0;
                end
                m_dly <= m_dly - 1;
            end
            mem_req_ready <= ($urandom % 4) != 0;
        end
    end

    // Output monitor, sampled at the falling edge
    logic          p_valid, p_ready;
    logic [AW-1:0] p_addr;
    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_irq) irq_cnt++;
            if (cfg_wr) begin
                if (rec) obs_q.push_back({cfg_addr, cfg_data});
                else if (exp_q.size() == 0) chk(1'b0, "R1 unexpected write", {cfg_addr, cfg_data}, 0);
                else begin
                    logic [47:0] e;
                    e = exp_q.pop_front();
                    chk({cfg_addr, cfg_data} == e, "R1 write order/content", {cfg_addr, cfg_data}, e);
                end
            end
            if (p_valid && !p_ready && (!mem_req_valid || mem_req_addr != p_addr))
                chk(1'b0, "R11 request dropped or changed", mem_req_addr, p_addr);
            if (!busy && (cfg_wr || mem_req_valid))
                chk(1'b0, "R10 activity while idle", {cfg_wr, mem_req_valid}, 0);
            p_valid = mem_req_valid;
            p_ready = mem_req_ready;
            p_addr  = mem_req_addr;
        end else begin
            p_valid = 1'b0;
            p_ready = 1'b0;
            p_addr  = '0;
        end
    end

    task automatic put_hdr(input int unsigned h, input int unsigned cnt,
                           input int unsigned flags, input int unsigned nxt);
        mem[h >> 2]             = cnt;
        mem[(h + OFF_NXT) >> 2] = nxt;
        mem[(h + OFF_FLG) >> 2] = flags;
    endtask

    task automatic put_body(input int unsigned h, input int unsigned b,
                            input int unsigned bytes, input int unsigned p);
        mem[(h + 4 + 8 * b) >> 2] = bytes;
        mem[(h + 8 + 8 * b) >> 2] = p;
    endtask

    task automatic fill_body(input int unsigned p, input int unsigned n);
        for (int e = 0; e < int'(n); e++) begin
            mem[(p + 8 * e) >> 2]     = $urandom;
            mem[(p + 8 * e + 4) >> 2] = $urandom;
        end
    endtask

    task automatic model_body(input int unsigned p, input int unsigned bytes);
        for (int e = 0; e < int'(bytes >> 3); e++)
            exp_q.push_back({mem[(p + 8 * e) >> 2][RAW-1:0], mem[(p + 8 * e + 4) >> 2]});
    endtask

    task automatic model_hdr(input int unsigned h);
        int unsigned cnt;
        cnt = mem[h >> 2];
        if (cnt > NB - 1) cnt = NB - 1;
        for (int b = 0; b <= int'(cnt); b++)
            model_body(mem[(h + 8 + 8 * b) >> 2], mem[(h + 4 + 8 * b) >> 2]);
    endtask

    task automatic launch(input bit hm, input int unsigned a, input int unsigned s);
        @(negedge clk);
        hdr_mode    = hm;
        launch_addr = a;
        launch_size = SW'(s);
        launch_wr   = 1'b1;
        @(negedge clk);
        launch_wr = 1'b0;
        chk(launch_upd == 1'b1, "R8 update bit after launch", launch_upd, 1);
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        while (busy || launch_upd) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int i0;
        void'($urandom(32'd4711));
        for (int k = 0; k < 2048; k++) mem[k] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && cfg_wr == 0 && frame_irq == 0 && launch_upd == 0 && mem_req_valid == 0,
            "R10 reset state", {busy, cfg_wr, frame_irq, launch_upd, mem_req_valid}, 0);

        // R1 R2 R5: one body, interrupt only
        put_hdr(32'h000, 0, 2, 0); put_body(32'h000, 0, 24, 32'h1000); fill_body(32'h1000, 3);
        model_hdr(32'h000);
        i0 = irq_cnt;
        launch(1'b1, 32'h000, 0);
        @(negedge clk);
        chk(busy == 1 && launch_upd == 0, "R8 idle engine takes launch", {busy, launch_upd}, 2'b10);
        wait_idle();
        chk(exp_q.size() == 0, "R1 all entries written", exp_q.size(), 0);
        chk(irq_cnt - i0 == 1, "R5 one interrupt", irq_cnt - i0, 1);
        chk(busy == 0, "R10 busy low after list", busy, 0);

        // R3 R4: three bodies with a zero-length middle body
        put_hdr(32'h080, 2, 2, 0);
        put_body(32'h080, 0, 16, 32'h1100); put_body(32'h080, 1, 0, 32'h1200);
        put_body(32'h080, 2, 8, 32'h1300);
        fill_body(32'h1100, 2); fill_body(32'h1200, 2); fill_body(32'h1300, 1);
        model_hdr(32'h080);
        chk(exp_q.size() == 3, "R4 zero body skipped in model", exp_q.size(), 3);
        launch(1'b1, 32'h080, 0);
        wait_idle();
        chk(exp_q.size() == 0, "R3 bodies in order", exp_q.size(), 0);

        // R3: count above NB-1 clamped
        put_hdr(32'h100, 6, 2, 0);
        for (int b = 0; b < int'(NB); b++) begin
            put_body(32'h100, b, 8, 32'h1400 + 32'h40 * b);
            fill_body(32'h1400 + 32'h40 * b, 1);
        end
        model_hdr(32'h100);
        launch(1'b1, 32'h100, 0);
        wait_idle();
        chk(exp_q.size() == 0, "R3 count clamp", exp_q.size(), 0);

        // R5 R6: chain A -> B, one interrupt
        put_hdr(32'h180, 0, 1, 32'h200); put_body(32'h180, 0, 32, 32'h1600); fill_body(32'h1600, 4);
        put_hdr(32'h200, 0, 2, 0);       put_body(32'h200, 0, 16, 32'h1700); fill_body(32'h1700, 2);
        model_hdr(32'h180); model_hdr(32'h200);
        i0 = irq_cnt;
        launch(1'b1, 32'h180, 0);
        wait_idle();
        chk(exp_q.size() == 0, "R6 chain followed", exp_q.size(), 0);
        chk(irq_cnt - i0 == 1, "R5 single interrupt for chain", irq_cnt - i0, 1);

        // R7: launch during a chain middle: A, B, then E
        put_hdr(32'h280, 0, 2, 0); put_body(32'h280, 0, 8, 32'h1800); fill_body(32'h1800, 1);
        model_hdr(32'h180); model_hdr(32'h200); model_hdr(32'h280);
        i0 = irq_cnt;
        launch(1'b1, 32'h180, 0);
        repeat (4) @(negedge clk);
        launch(1'b1, 32'h280, 0);
        wait_idle();
        chk(exp_q.size() == 0, "R7 chain before pending", exp_q.size(), 0);
        chk(irq_cnt - i0 == 2, "R7 interrupts", irq_cnt - i0, 2);

        // R6 R7: self-looping list replaced by a new launch
        put_hdr(32'h300, 0, 3, 32'h300); put_body(32'h300, 0, 16, 32'h1900); fill_body(32'h1900, 2);
        rec = 1'b1;
        obs_q.delete();
        i0 = irq_cnt;
        launch(1'b1, 32'h300, 0);
        while (irq_cnt - i0 < 3) @(negedge clk);
        chk(busy == 1, "R6 loop keeps running", busy, 1);
        launch(1'b1, 32'h280, 0);
        wait_idle();
        rec = 1'b0;
        begin
            int nobs;
            bit ok;
            nobs = obs_q.size();
            ok = (nobs >= 7) && (((nobs - 1) % 2) == 0);
            if (ok) begin
                ok = obs_q[nobs-1] == {mem[32'h1800 >> 2][RAW-1:0], mem[(32'h1800 + 4) >> 2]};
                for (int k = 0; k < nobs - 1; k++)
                    if (obs_q[k] != {mem[(32'h1900 + 8 * (k % 2)) >> 2][RAW-1:0],
                                     mem[(32'h1900 + 8 * (k % 2) + 4) >> 2]}) ok = 1'b0;
            end
            chk(ok, "R6 loop repeats then R7 replacement", nobs, 7);
        end

        // R9: headerless body, then size zero
        fill_body(32'h1A00, 2);
        model_body(32'h1A00, 16);
        i0 = irq_cnt;
        launch(1'b0, 32'h1A00, 16);
        @(negedge clk);
        chk(launch_upd == 0 && busy == 1, "R9 update bit cleared on start", {launch_upd, busy}, 1);
        wait_idle();
        chk(exp_q.size() == 0, "R9 headerless writes", exp_q.size(), 0);
        chk(irq_cnt - i0 == 1, "R9 headerless interrupt", irq_cnt - i0, 1);
        i0 = irq_cnt;
        launch(1'b0, 32'h1A00, 0);
        wait_idle();
        chk(irq_cnt - i0 == 1, "R9 size zero still interrupts", irq_cnt - i0, 1);
        chk(exp_q.size() == 0, "R4 size zero writes nothing", exp_q.size(), 0);

        // Random lists
        for (int it = 0; it < 12; it++) begin
            int unsigned cnt;
            cnt = $urandom % (NB + 2);
            put_hdr(32'h400, cnt, 2, 0);
            for (int b = 0; b < int'(NB); b++) begin
                int unsigned ln;
                ln = $urandom % 4;
                put_body(32'h400, b, 8 * ln, 32'h1C00 + 32'h40 * b);
                fill_body(32'h1C00 + 32'h40 * b, ln);
            end
            model_hdr(32'h400);
            i0 = irq_cnt;
            launch(1'b1, 32'h400, 0);
            wait_idle();
            chk(exp_q.size() == 0, "R1 random list complete", exp_q.size(), 0);
            chk(irq_cnt - i0 == 1, "R5 random list interrupt", irq_cnt - i0, 1);
        end

        finish_run();
    end
endmodule